// File: doc/BRIEF.md
# Five-Source Interrupt Status Controller

This block keeps the interrupt bookkeeping for five requesters: two parallel ports (A and B) and three counter/timers (T1, T2, T3). Every source has four state bits: pending, enable, in-service and overrun error. Software never writes these bits directly. It selects a source and writes a 3-bit command code, and each code sets or clears one bit, or clears pending and in-service together. A one-cycle event strobe from a source marks it pending. A strobe that arrives while the source is already pending also records an overrun error.

The block builds an 8-bit vector for each source from a software-supplied base byte. When status insertion is enabled, the low bits of the port vectors are replaced by the port's own flags, and the low bits of the timer vectors are replaced by a code that names the timer. A current-vector output gives the vector of the most urgent pending, enabled source. A single request line tells the interrupt fabric whether any source may interrupt now. A source that is in service blocks itself and every source of lower priority.

Top module: `irqc_top`

## Requirements
- R1: A write with `wr_en` high applies `wr_cmd` to the source selected by `wr_src` (0 port A, 1 T1, 2 port B, 3 T2, 4 T3; codes 5 to 7 select nothing). The command codes are: 0 no change; 1 clear pending and in-service; 2 set in-service; 3 clear in-service; 4 set pending; 5 clear pending; 6 set enable; 7 clear enable.
- R2: A strobe on `evt_strobe[i]` sets pending of source i. If pending was already set, the strobe also sets the error bit. Command codes 1 and 5 clear the error bit, except when a strobe sets it in the same cycle. Setting pending with code 4 never sets the error bit.
- R3: `rd_status` returns the state of source `rd_src` as in-service in bit 7, enable in bit 6, pending in bit 5 and error in bit 4. Bits 3..0 read 0. An `rd_src` of 5 or more reads 00h.
- R4: When status insertion is on, a port vector is its base byte with bits 3..1 replaced. They become 000 if the port's error bit is set. Otherwise they become the port flags, with flag bit 2 (output empty) in bit 3, flag bit 1 (input full) in bit 2 and flag bit 0 (pattern match) in bit 1.
- R5: When status insertion is on, a timer vector is the shared timer base byte with bits 2..1 replaced. They become 3 if that timer's error bit is set. Otherwise they become the timer code: T1 is 2, T2 is 1 and T3 is 0. Bit 3 and all other bits keep their base value.
- R6: Status insertion has three separate enables: one for port A, one for port B and one for the timer group. With an enable off, the vectors it governs equal their base byte.
- R7: `cur_vec` is the vector of the first source with both pending and enable set, in the order port A, T1, port B, T2, T3. It is FFh when no such source exists. In-service and the master enable do not affect it.
- R8: While `cfg_no_vec` is high, `cur_vec` is FFh.
- R9: `irq_req` is high only when `cfg_master_en` is high and some source has both pending and enable set with no in-service bit set at that source or at any source ahead of it in the R7 order.
- R10: After reset, all state bits are 0, `cur_vec` is FFh, `irq_req` is 0 and `rd_status` is 00h.
- R11: All outputs are registered. A change in source state caused by a write or strobe sampled at clock edge k reaches the outputs at edge k+1. A change on a configuration, flag, base or `rd_src` input reaches the outputs at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command write strobe |
| wr_src | input | 3 | Source targeted by the command |
| wr_cmd | input | 3 | Command code |
| evt_strobe | input | 5 | Per-source event strobes, bit i for source i |
| pa_flags | input | 3 | Port A flags {output empty, input full, pattern match} |
| pb_flags | input | 3 | Port B flags, same layout |
| cfg_master_en | input | 1 | Master gate for `irq_req` |
| cfg_no_vec | input | 1 | Forces `cur_vec` to FFh |
| cfg_pa_stat | input | 1 | Status insertion for the port A vector |
| cfg_pb_stat | input | 1 | Status insertion for the port B vector |
| cfg_ct_stat | input | 1 | Status insertion for the timer vectors |
| pa_vec_base | input | 8 | Port A base vector |
| pb_vec_base | input | 8 | Port B base vector |
| ct_vec_base | input | 8 | Shared timer base vector |
| rd_src | input | 3 | Source whose state appears on `rd_status` |
| rd_status | output | 8 | State read of the selected source |
| src_vec | output | 40 | Per-source vectors, source i in bits 8i+7..8i |
| cur_vec | output | 8 | Vector of the most urgent pending, enabled source |
| irq_req | output | 1 | Interrupt request |

## Verification
A strobe or command sampled at one edge changes the state registers at that edge. The registered outputs show the change one edge later. The bench therefore drives each stimulus at a falling edge, drops the strobes after the first rising edge, and samples at the falling edge that follows the second rising edge. Configuration, flag, base and read-select changes move the outputs after a single edge. The bench waits one full cycle after each such change before it samples. Every result is read in mid-cycle, well away from the edge that produces it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC  = 5;
  localparam int SRC_W = $clog2(NSRC);
  localparam int VEC_W = 8;
  localparam int FLG_W = 3;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP          = 3'd0,
    CMD_CLR_PEND_SVC = 3'd1,
    CMD_SET_SVC      = 3'd2,
    CMD_CLR_SVC      = 3'd3,
    CMD_SET_PEND     = 3'd4,
    CMD_CLR_PEND     = 3'd5,
    CMD_SET_EN       = 3'd6,
    CMD_CLR_EN       = 3'd7
  } irq_cmd_e;

  typedef struct packed {
    logic svc;
    logic en;
    logic pend;
    logic err;
  } src_state_t;

  // priority order: index 0 is most urgent
  function automatic bit src_is_port(int idx);
    return (idx == 0) || (idx == 2);
  endfunction

  function automatic logic [1:0] src_tmr_code(int idx);
    case (idx)
      1:       return 2'd2;
      3:       return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/irqc_src_cell.sv
module irqc_src_cell
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_hit,
  input  irq_cmd_e   cmd,
  input  logic       strobe,
  output src_state_t st
);
  src_state_t st_n;

  always_comb begin
    st_n = st;
    if (cmd_hit) begin
      unique case (cmd)
        CMD_NOP:          ;
        CMD_CLR_PEND_SVC: begin st_n.pend = 1'b0; st_n.svc = 1'b0; st_n.err = 1'b0; end
        CMD_SET_SVC:      st_n.svc  = 1'b1;
        CMD_CLR_SVC:      st_n.svc  = 1'b0;
        CMD_SET_PEND:     st_n.pend = 1'b1;
        CMD_CLR_PEND:     begin st_n.pend = 1'b0; st_n.err = 1'b0; end
        CMD_SET_EN:       st_n.en   = 1'b1;
        CMD_CLR_EN:       st_n.en   = 1'b0;
      endcase
    end
    if (strobe) begin
      st_n.pend = 1'b1;
      if (st.pend) st_n.err = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= st_n;
  end

  assert_strobe_pends_R2: assert property (@(posedge clk) disable iff (rst)
    strobe |=> st.pend);
  assert_overrun_err_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe && st.pend) |=> st.err);
  assert_en_set_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && cmd == CMD_SET_EN) |=> st.en);
  assert_svc_clr_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && cmd == CMD_CLR_SVC) |=> !st.svc);
endmodule

// File: rtl/irqc_vec_fmt.sv
module irqc_vec_fmt
  import irqc_pkg::*;
#(
  parameter bit         PORT_SRC = 1'b1,
  parameter logic [1:0] TMR_CODE = 2'd0
)(
  input  logic [VEC_W-1:0] base,
  input  logic             stat_en,
  input  logic [FLG_W-1:0] flags,
  input  logic             err,
  output logic [VEC_W-1:0] vec
);
  generate
    if (PORT_SRC) begin : g_port
      always_comb begin
        vec = base;
        if (stat_en) vec[3:1] = err ? 3'b000 : flags;
      end
    end else begin : g_tmr
      logic unused_flags;
      assign unused_flags = ^flags;
      always_comb begin
        vec = base;
        if (stat_en) vec[2:1] = err ? 2'b11 : TMR_CODE;
      end
    end
  endgenerate
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
(
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  en,
  input  logic [NSRC-1:0]  svc,
  output logic             pick_vld,
  output logic [SRC_W-1:0] pick_idx,
  output logic             req_any
);
  logic blocked;

  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i] && en[i]) begin
        pick_vld = 1'b1;
        pick_idx = SRC_W'(i);
      end
    end
  end

  always_comb begin
    blocked = 1'b0;
    req_any = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      blocked = blocked | svc[i];
      if (!blocked && pend[i] && en[i]) req_any = 1'b1;
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [SRC_W-1:0]      wr_src,
  input  logic [CMD_W-1:0]      wr_cmd,
  input  logic [NSRC-1:0]       evt_strobe,
  input  logic [FLG_W-1:0]      pa_flags,
  input  logic [FLG_W-1:0]      pb_flags,
  input  logic                  cfg_master_en,
  input  logic                  cfg_no_vec,
  input  logic                  cfg_pa_stat,
  input  logic                  cfg_pb_stat,
  input  logic                  cfg_ct_stat,
  input  logic [VEC_W-1:0]      pa_vec_base,
  input  logic [VEC_W-1:0]      pb_vec_base,
  input  logic [VEC_W-1:0]      ct_vec_base,
  input  logic [SRC_W-1:0]      rd_src,
  output logic [VEC_W-1:0]      rd_status,
  output logic [NSRC*VEC_W-1:0] src_vec,
  output logic [VEC_W-1:0]      cur_vec,
  output logic                  irq_req
);
  localparam logic [VEC_W-1:0] NO_VEC = '1;

  src_state_t              st [NSRC];
  logic [VEC_W-1:0]        vec_arr [NSRC];
  logic [NSRC-1:0]         pend_v, en_v, svc_v;
  logic [NSRC*VEC_W-1:0]   src_vec_n;
  logic                    pick_vld, req_any;
  logic [SRC_W-1:0]        pick_idx;
  logic [VEC_W-1:0]        cur_vec_n, rd_status_n;
  irq_cmd_e                cmd_e;

  assign cmd_e = irq_cmd_e'(wr_cmd);

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_src
      irqc_src_cell u_cell (
        .clk    (clk),
        .rst    (rst),
        .cmd_hit(wr_en && (wr_src == SRC_W'(i))),
        .cmd    (cmd_e),
        .strobe (evt_strobe[i]),
        .st     (st[i])
      );
      assign pend_v[i] = st[i].pend;
      assign en_v[i]   = st[i].en;
      assign svc_v[i]  = st[i].svc;

      if (src_is_port(i)) begin : g_pv
        irqc_vec_fmt #(.PORT_SRC(1'b1), .TMR_CODE(2'd0)) u_fmt (
          .base   ((i == 0) ? pa_vec_base : pb_vec_base),
          .stat_en((i == 0) ? cfg_pa_stat : cfg_pb_stat),
          .flags  ((i == 0) ? pa_flags    : pb_flags),
          .err    (st[i].err),
          .vec    (vec_arr[i])
        );
      end else begin : g_tv
        irqc_vec_fmt #(.PORT_SRC(1'b0), .TMR_CODE(src_tmr_code(i))) u_fmt (
          .base   (ct_vec_base),
          .stat_en(cfg_ct_stat),
          .flags  ('0),
          .err    (st[i].err),
          .vec    (vec_arr[i])
        );
      end
      assign src_vec_n[i*VEC_W +: VEC_W] = vec_arr[i];
    end
  endgenerate

  irqc_prio u_prio (
    .pend    (pend_v),
    .en      (en_v),
    .svc     (svc_v),
    .pick_vld(pick_vld),
    .pick_idx(pick_idx),
    .req_any (req_any)
  );

  always_comb begin
    cur_vec_n = NO_VEC;
    if (pick_vld && !cfg_no_vec) cur_vec_n = vec_arr[pick_idx];
  end

  always_comb begin
    rd_status_n = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (rd_src == SRC_W'(k))
        rd_status_n = {st[k].svc, st[k].en, st[k].pend, st[k].err, 4'b0000};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_vec   <= NO_VEC;
      irq_req   <= 1'b0;
      rd_status <= '0;
      src_vec   <= '0;
    end else begin
      cur_vec   <= cur_vec_n;
      irq_req   <= cfg_master_en && req_any;
      rd_status <= rd_status_n;
      src_vec   <= src_vec_n;
    end
  end

  assert_no_vec_blank_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_no_vec |=> (cur_vec == NO_VEC));
  assert_idle_blank_R7: assert property (@(posedge clk) disable iff (rst)
    !(|(pend_v & en_v)) |=> (cur_vec == NO_VEC));
  assert_master_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_master_en |=> !irq_req);
  assert_head_svc_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    svc_v[0] |=> !irq_req);
endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_src = '0, wr_cmd = '0, rd_src = '0;
  logic [4:0]  evt_strobe = '0;
  logic [2:0]  pa_flags = 3'b010, pb_flags = 3'b001;
  logic        cfg_master_en = 1'b1, cfg_no_vec = 1'b0;
  logic        cfg_pa_stat = 1'b1, cfg_pb_stat = 1'b1, cfg_ct_stat = 1'b1;
  logic [7:0]  pa_vec_base = 8'h40, pb_vec_base = 8'h60, ct_vec_base = 8'h80;
  logic [7:0]  rd_status, cur_vec;
  logic [39:0] src_vec;
  logic        irq_req;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  irqc_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_src(wr_src), .wr_cmd(wr_cmd),
    .evt_strobe(evt_strobe), .pa_flags(pa_flags), .pb_flags(pb_flags),
    .cfg_master_en(cfg_master_en), .cfg_no_vec(cfg_no_vec),
    .cfg_pa_stat(cfg_pa_stat), .cfg_pb_stat(cfg_pb_stat), .cfg_ct_stat(cfg_ct_stat),
    .pa_vec_base(pa_vec_base), .pb_vec_base(pb_vec_base), .ct_vec_base(ct_vec_base),
    .rd_src(rd_src), .rd_status(rd_status), .src_vec(src_vec),
    .cur_vec(cur_vec), .irq_req(irq_req)
  );

  // {wr, src, cmd, strobes[4:0], expected cur_vec, expected irq_req}
  localparam int NV = 18;
  localparam logic [20:0] TBL [NV] = '{
    {1'b0, 3'd0, 3'd0, 5'b10000, 8'hFF, 1'b0},
    {1'b1, 3'd4, 3'd6, 5'b00000, 8'h80, 1'b1},
    {1'b1, 3'd3, 3'd6, 5'b01000, 8'h82, 1'b1},
    {1'b1, 3'd3, 3'd2, 5'b00000, 8'h82, 1'b0},
    {1'b1, 3'd0, 3'd6, 5'b00001, 8'h44, 1'b1},
    {1'b1, 3'd0, 3'd5, 5'b00000, 8'h82, 1'b0},
    {1'b1, 3'd3, 3'd3, 5'b00000, 8'h82, 1'b1},
    {1'b1, 3'd3, 3'd5, 5'b00000, 8'h80, 1'b1},
    {1'b0, 3'd0, 3'd0, 5'b10000, 8'h86, 1'b1},
    {1'b1, 3'd4, 3'd1, 5'b00000, 8'hFF, 1'b0},
    {1'b1, 3'd1, 3'd6, 5'b00010, 8'h84, 1'b1},
    {1'b1, 3'd1, 3'd7, 5'b00000, 8'hFF, 1'b0},
    {1'b1, 3'd1, 3'd6, 5'b00000, 8'h84, 1'b1},
    {1'b1, 3'd2, 3'd6, 5'b00100, 8'h84, 1'b1},
    {1'b1, 3'd1, 3'd5, 5'b00000, 8'h62, 1'b1},
    {1'b1, 3'd2, 3'd4, 5'b00000, 8'h62, 1'b1},
    {1'b0, 3'd0, 3'd0, 5'b00100, 8'h60, 1'b1},
    {1'b1, 3'd2, 3'd1, 5'b00000, 8'hFF, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [2:0] s, input logic [2:0] c,
                      input logic [4:0] b);
    @(negedge clk);
    wr_en = w; wr_src = s; wr_cmd = c; evt_strobe = b;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; evt_strobe = '0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    settle();
    // R10 reset state
    chk("R10 cur_vec", cur_vec, 8'hFF);
    chk("R10 irq_req", {7'b0, irq_req}, 8'h00);
    chk("R10 rd_status", rd_status, 8'h00);

    // table: R1 R2 R4 R5 R7 R9 R11
    for (int v = 0; v < NV; v++) begin
      step(TBL[v][20], TBL[v][19:17], TBL[v][16:14], TBL[v][13:9]);
      chk($sformatf("R7 cur_vec vec %0d", v), cur_vec, TBL[v][8:1]);
      chk($sformatf("R9 irq_req vec %0d", v), {7'b0, irq_req}, {7'b0, TBL[v][0]});
    end

    // R3 / R2 status read on T2 (all enables are now set)
    rd_src = 3'd3;
    step(1'b0, 3'd0, 3'd0, 5'b01000);
    chk("R3 status pend", rd_status, 8'h60);
    step(1'b0, 3'd0, 3'd0, 5'b01000);
    chk("R2 status overrun", rd_status, 8'h70);
    step(1'b1, 3'd3, 3'd2, 5'b00000);
    chk("R1 status set svc", rd_status, 8'hF0);
    step(1'b1, 3'd3, 3'd0, 5'b00000);
    chk("R1 nop no change", rd_status, 8'hF0);
    step(1'b1, 3'd3, 3'd1, 5'b00000);
    chk("R1 clear pend+svc", rd_status, 8'h40);
    step(1'b1, 3'd6, 3'd6, 5'b00000);
    chk("R1 out-of-range src", rd_status, 8'h40);
    rd_src = 3'd7;
    settle();
    chk("R3 out-of-range read", rd_status, 8'h00);

    // R9 port A in service blocks a lower source
    step(1'b0, 3'd0, 3'd0, 5'b10000);
    chk("R9 T3 requests", {7'b0, irq_req}, 8'h01);
    step(1'b1, 3'd0, 3'd2, 5'b00000);
    chk("R9 head svc blocks", {7'b0, irq_req}, 8'h00);
    chk("R7 svc ignored", cur_vec, 8'h80);
    step(1'b1, 3'd0, 3'd3, 5'b00000);
    chk("R9 unblocked", {7'b0, irq_req}, 8'h01);

    // R9 master gate, R8 no-vector
    cfg_master_en = 1'b0; settle();
    chk("R9 master off", {7'b0, irq_req}, 8'h00);
    chk("R7 master ignored", cur_vec, 8'h80);
    cfg_master_en = 1'b1; cfg_no_vec = 1'b1; settle();
    chk("R8 no vec", cur_vec, 8'hFF);
    cfg_no_vec = 1'b0; settle();
    chk("R8 restored", cur_vec, 8'h80);

    // R5 / R6 timer status insertion
    ct_vec_base = 8'hF7; settle();
    chk("R5 T3 code", cur_vec, 8'hF1);
    chk("R5 T1 code", src_vec[15:8], 8'hF5);
    chk("R5 T2 code", src_vec[31:24], 8'hF3);
    cfg_ct_stat = 1'b0; settle();
    chk("R6 timer stat off", cur_vec, 8'hF7);
    cfg_ct_stat = 1'b1;

    // R4 / R6 port status insertion
    pa_flags = 3'b101; settle();
    chk("R4 port A flags", src_vec[7:0], 8'h4A);
    cfg_pa_stat = 1'b0; settle();
    chk("R6 port A stat off", src_vec[7:0], 8'h40);
    chk("R6 port B stays on", src_vec[23:16], 8'h62);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule